// File: doc/BRIEF.md
# DRAM Rank Refresh Scheduler

This block keeps one DRAM rank of eight banks within its retention limit by issuing refresh operations at a steady rate. A free-running interval counter adds one refresh credit each period. While credits are outstanding and the block is idle, it raises a request to the command arbiter. Once the arbiter grants the request and any access already on the rank has finished, the block holds a rank-busy signal for a fixed number of cycles. That window is sized for eight rows refreshed in parallel in every bank, which is 64 rows per operation. During the window the arbiter must send no reads or writes to the rank.

Each completed refresh advances a row-group index. The index covers the whole rank in 8K steps at default sizing, which is one full 64 ms retention window, and a one-cycle marker flags each wrap to zero. The arbiter may defer refresh for a while. Credits pile up to a ceiling of eight. At that ceiling a forced flag goes high and the block starts the next refresh without waiting for a grant.

Top module: `dram_ref_sched`

## Requirements
- R1: While rst_ni is low and in the first cycle after it is released, ref_req_o, ref_force_o, rank_busy_o and window_done_o are 0 and row_grp_o is 0.
- R2: The block earns one refresh credit every INTERVAL_CYC clock cycles. The first credit is earned at the INTERVAL_CYC-th rising edge after reset release.
- R3: ref_req_o is 1 exactly when at least one credit is outstanding and the block is neither waiting to start nor refreshing. It is never 1 together with rank_busy_o.
- R4: A grant is accepted in a cycle where ref_req_o is 1 and ref_gnt_i is 1. rank_busy_o rises at the first rising edge at which acc_busy_i was sampled 0, counting from the edge that accepts the grant. It never rises while acc_busy_i is held 1.
- R5: Each time rank_busy_o goes high, it stays 1 for exactly BUSY_CYC consecutive cycles.
- R6: Outstanding credits never exceed MAX_PEND (8). Further credits are dropped. ref_force_o is 1 exactly when the count equals MAX_PEND.
- R7: While ref_force_o is 1 and the block is idle, a refresh is accepted without ref_gnt_i.
- R8: row_grp_o increments by one at the edge where rank_busy_o falls and wraps from NUM_GROUPS-1 to 0. window_done_o is 1 for exactly the one cycle after the wrap.
- R9: ref_gnt_i has no effect while ref_req_o is 0.
- R10: A credit is consumed at the edge where rank_busy_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_busy_i | input | 1 | An access to the rank is in flight |
| ref_gnt_i | input | 1 | Arbiter grants the refresh request |
| ref_req_o | output | 1 | Refresh requested |
| ref_force_o | output | 1 | Credit ceiling reached; refresh is mandatory |
| rank_busy_o | output | 1 | Rank unavailable: refresh in progress |
| row_grp_o | output | $clog2(NUM_GROUPS) | Row group refreshed next |
| window_done_o | output | 1 | One-cycle marker when the row-group index wraps |

## Verification
The hardest state to reach is the credit ceiling. The arbiter has to withhold grants for at least eight full intervals while accesses stay quiet, and only then does the forced path start refreshes by itself and drain the backlog back to back. The bench withholds grants for that long on purpose. It also holds acc_busy_i high across an accepted grant to test the drain wait. A small interval and a small row-group count let random grant and access traffic cover several index wraps. A cycle model built from the requirements predicts every output on every cycle.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_REF   = 2'd2
  } ref_state_e;
endpackage

// File: rtl/dref_tick.sv
module dref_tick #(
  parameter int unsigned INTERVAL_CYC = 1950
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RELOAD;
    else if (tick_o) cnt_q <= RELOAD;
    else             cnt_q <= cnt_q - 1'b1;
  end

  // credit pulses are isolated when the period exceeds one cycle
  p_tick_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/dref_pend.sv
module dref_pend #(
  parameter int unsigned MAX_PEND = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic take_i,
  output logic pend_nz_o,
  output logic force_o
);
  localparam int unsigned PW = $clog2(MAX_PEND + 1);
  localparam logic [PW-1:0] PMAX = PW'(MAX_PEND);

  logic [PW-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    unique case ({tick_i, take_i})
      2'b10:   if (pend_q != PMAX) pend_d = pend_q + 1'b1;
      2'b01:   pend_d = pend_q - 1'b1;
      default: pend_d = pend_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_nz_o = (pend_q != '0);
  assign force_o   = (pend_q == PMAX);

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= PMAX);
  p_take_credit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pend_q != '0);
endmodule

// File: rtl/dref_fsm.sv
module dref_fsm
  import dref_pkg::*;
#(
  parameter int unsigned BUSY_CYC = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_nz_i,
  input  logic force_i,
  input  logic gnt_i,
  input  logic acc_busy_i,
  output logic req_o,
  output logic busy_o,
  output logic take_o,
  output logic done_o
);
  localparam int unsigned BW = (BUSY_CYC > 2) ? $clog2(BUSY_CYC) : 1;
  localparam logic [BW-1:0] BLOAD = BW'(BUSY_CYC - 1);

  ref_state_e st_q, st_d;
  logic [BW-1:0] bcnt_q;
  logic accept;

  assign req_o  = (st_q == ST_IDLE) && pend_nz_i;
  assign accept = req_o && (gnt_i || force_i);
  assign take_o = (accept && !acc_busy_i) || ((st_q == ST_DRAIN) && !acc_busy_i);
  assign done_o = (st_q == ST_REF) && (bcnt_q == '0);
  assign busy_o = (st_q == ST_REF);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept) st_d = acc_busy_i ? ST_DRAIN : ST_REF;
      ST_DRAIN: if (!acc_busy_i) st_d = ST_REF;
      ST_REF:   if (bcnt_q == '0) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bcnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (take_o)              bcnt_q <= BLOAD;
      else if (st_q == ST_REF) bcnt_q <= bcnt_q - 1'b1;
    end
  end

  p_start_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(acc_busy_i));
  p_hold_window_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REF && bcnt_q != '0) |=> st_q == ST_REF);
  p_drain_stay_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DRAIN && acc_busy_i) |=> st_q == ST_DRAIN);
endmodule

// File: rtl/dref_rowptr.sv
module dref_rowptr #(
  parameter int unsigned NUM_GROUPS = 8192
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          adv_i,
  output logic [$clog2(NUM_GROUPS)-1:0] grp_o,
  output logic                          wrap_o
);
  localparam int unsigned GW = $clog2(NUM_GROUPS);
  localparam logic [GW-1:0] LAST = GW'(NUM_GROUPS - 1);

  logic [GW-1:0] grp_q, grp_inc;
  logic wrap_q;

  generate
    if ((1 << GW) == NUM_GROUPS) begin : g_pow2
      assign grp_inc = grp_q + 1'b1;
    end else begin : g_mod
      assign grp_inc = (grp_q == LAST) ? '0 : grp_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= adv_i && (grp_q == LAST);
      if (adv_i) grp_q <= grp_inc;
    end
  end

  assign grp_o  = grp_q;
  assign wrap_o = wrap_q;

  p_in_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_q <= LAST);
endmodule

// File: rtl/dram_ref_sched.sv
module dram_ref_sched #(
  parameter int unsigned INTERVAL_CYC = 1950,
  parameter int unsigned BUSY_CYC     = 80,
  parameter int unsigned MAX_PEND     = 8,
  parameter int unsigned NUM_GROUPS   = 8192
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          acc_busy_i,
  input  logic                          ref_gnt_i,
  output logic                          ref_req_o,
  output logic                          ref_force_o,
  output logic                          rank_busy_o,
  output logic [$clog2(NUM_GROUPS)-1:0] row_grp_o,
  output logic                          window_done_o
);
  logic tick, take, done, pend_nz;

  dref_tick #(.INTERVAL_CYC(INTERVAL_CYC)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  dref_pend #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .take_i(take),
    .pend_nz_o(pend_nz), .force_o(ref_force_o)
  );

  dref_fsm #(.BUSY_CYC(BUSY_CYC)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_nz_i(pend_nz), .force_i(ref_force_o),
    .gnt_i(ref_gnt_i), .acc_busy_i(acc_busy_i), .req_o(ref_req_o),
    .busy_o(rank_busy_o), .take_o(take), .done_o(done)
  );

  dref_rowptr #(.NUM_GROUPS(NUM_GROUPS)) u_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(done),
    .grp_o(row_grp_o), .wrap_o(window_done_o)
  );

  p_req_not_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rank_busy_o |-> !ref_req_o);
  p_grp_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_grp_o != $past(row_grp_o)) |-> $fell(rank_busy_o));
  p_wrap_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    window_done_o |-> row_grp_o == '0);
endmodule

// File: tb/dram_ref_sched_test.sv
module dram_ref_sched_test;
  localparam int INT = 40;
  localparam int BUSY = 6;
  localparam int MAXP = 8;
  localparam int GRPS = 16;

  logic clk = 1'b0, rst_ni = 1'b0, acc = 1'b0, gnt = 1'b0;
  logic req, frc, busy, wdone;
  logic [3:0] grp;

  int total = 0, bad = 0, cyc = 0;
  bit run_cmp = 0, finished = 0;

  int m_tick, m_pend, m_st, m_b, m_grp;
  bit m_wrap;
  int busy_run = 0, forced_starts = 0, wraps = 0;

  always #2 clk = ~clk;

  dram_ref_sched #(.INTERVAL_CYC(INT), .BUSY_CYC(BUSY), .MAX_PEND(MAXP), .NUM_GROUPS(GRPS)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .acc_busy_i(acc), .ref_gnt_i(gnt),
    .ref_req_o(req), .ref_force_o(frc), .rank_busy_o(busy),
    .row_grp_o(grp), .window_done_o(wdone)
  );

  function automatic bit f_req(int st, int p); return st == 0 && p > 0; endfunction
  function automatic bit f_force(int p); return p == MAXP; endfunction

  task automatic check(int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", what, act, exp, $time);
    end
  endtask

  // requirement-level cycle model
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_tick <= INT - 1; m_pend <= 0; m_st <= 0; m_b <= 0; m_grp <= 0; m_wrap <= 0;
    end else begin
      bit tk, acpt, tk_take, dn;
      tk = (m_tick == 0);
      acpt = f_req(m_st, m_pend) && (gnt || f_force(m_pend));
      tk_take = (acpt && !acc) || (m_st == 1 && !acc);
      dn = (m_st == 2) && (m_b == 0);
      m_tick <= tk ? INT - 1 : m_tick - 1;
      if (tk && !tk_take) m_pend <= (m_pend < MAXP) ? m_pend + 1 : m_pend;
      else if (!tk && tk_take) m_pend <= m_pend - 1;
      if (tk_take) begin m_st <= 2; m_b <= BUSY - 1; end
      else if (acpt) m_st <= 1;
      else if (dn) m_st <= 0;
      else if (m_st == 2) m_b <= m_b - 1;
      if (tk_take && acpt && f_force(m_pend) && !gnt) forced_starts++;
      m_wrap <= dn && (m_grp == GRPS - 1);
      if (dn) m_grp <= (m_grp + 1) % GRPS;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (run_cmp && rst_ni) begin
      check(req, f_req(m_st, m_pend), "R3 ref_req_o");
      check(frc, f_force(m_pend), "R6 ref_force_o");
      check(busy, m_st == 2, "R4 rank_busy_o");
      check(grp, m_grp, "R8 row_grp_o");
      check(wdone, m_wrap, "R8 window_done_o");
      if (busy) busy_run++;
      else if (busy_run != 0) begin
        check(busy_run, BUSY, "R5 busy length");
        busy_run = 0;
      end
      if (wdone) begin
        wraps++;
        check(grp, 0, "R8 wrap value");
      end
    end
    if (cyc > 100000 && !finished) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int c0, fs0;
    void'($urandom(32'h5eed));
    cycles(3);
    check(req, 0, "R1 req in reset");
    check(busy, 0, "R1 busy in reset");
    check(frc, 0, "R1 force in reset");
    check(grp, 0, "R1 grp in reset");
    check(wdone, 0, "R1 done in reset");
    rst_ni = 1'b1;
    run_cmp = 1;
    // R2: credit at edge INT, request visible afterwards
    cycles(INT - 1);
    check(req, 0, "R2 no request before interval");
    cycles(1);
    check(req, 1, "R2 request after interval");
    // R9: random grants while req low are covered by the model
    for (int i = 0; i < 3000; i++) begin
      gnt = ($urandom % 4) == 0;
      acc = ($urandom % 3) == 0;
      cycles(1);
    end
    // R4: access held across accepted grant blocks busy
    gnt = 1'b0; acc = 1'b1;
    while (!req) cycles(1);
    gnt = 1'b1;
    cycles(1);
    gnt = 1'b0;
    c0 = 0;
    for (int i = 0; i < 60; i++) begin cycles(1); if (busy) c0++; end
    check(c0, 0, "R4 busy while access in flight");
    acc = 1'b0;
    cycles(1);
    check(busy, 1, "R4 busy after access ends");
    // R6/R7: withhold grants until ceiling
    fs0 = forced_starts;
    c0 = 0;
    for (int i = 0; i < (MAXP + 2) * INT; i++) begin cycles(1); if (frc) c0++; end
    check(c0 > 0, 1, "R6 force reached");
    check(forced_starts > fs0, 1, "R7 start without grant");
    // more random traffic
    for (int i = 0; i < 3000; i++) begin
      gnt = ($urandom % 2) == 0;
      acc = ($urandom % 5) == 0;
      cycles(1);
    end
    gnt = 1'b1; acc = 1'b0;
    cycles(20 * INT);
    check(wraps >= 2, 1, "R8 several wraps seen");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule